// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between a 64-bit logical data path and a parallel bus whose data wires are active-low. A logical 1 on the internal word shows up as a low wire, and low wires cost power. The word is split into four 16-bit groups, and each group has its own active-low inversion flag.

On the transmit side, the block counts how many wires in each group would be pulled low. If that count is a strict majority of the group, the group is sent bit-inverted and its flag wire is pulled low. On the receive side, each group is restored by looking at its sampled flag. Every transfer phase is judged alone; no state carries from one phase to the next.

Both directions use valid/ready streams. A beat moves only in a cycle where valid and ready are both high. A source holds its valid, data and flags steady until the beat is taken. The transmit stage is always one register deep. While its output is stalled (valid high, ready low), it deasserts its input ready and freezes its output. The receive stage is either combinational, in which case ready and valid pass straight through, or one register deep with the same stall rules, selected by `RX_REG`.

Top module: `dbi_codec`

## Requirements
- R1: Group g (g = 0..3) is data bits [16g+15:16g] and is governed by flag bit g, on both transmit and receive.
- R2: A flag wire at 0 means its group is inverted on the bus; a flag wire at 1 means the group carries the plain active-low level (wire = NOT data).
- R3: On transmit, a group whose logical data has 9 or more ones (9+ low wires) is driven with wire = data and flag = 0.
- R4: On transmit, a group with 8 or fewer ones is driven with wire = NOT data and flag = 1; exactly 8 ones is not inverted.
- R5: Whenever tx_out_valid is high, no group of tx_bus_wires has more than 8 zeros.
- R6: Receive restores each group: data = wire when its flag is 0, data = NOT wire when its flag is 1, so decoding an encoded beat returns the original word.
- R7: The coding of each beat depends only on that beat's data; a beat after an inverted beat is coded as if alone.
- R8: A transmit beat accepted at a clock edge is presented on tx_out_valid/tx_bus_* right after that edge (one cycle latency).
- R9: While tx_out_valid is high and tx_out_ready low, tx_in_ready is low and tx_bus_wires/tx_bus_flag_n stay unchanged.
- R10: With RX_REG = 0 the receive path is combinational: rx_out_valid equals rx_in_valid and rx_in_ready equals rx_out_ready in the same cycle; with RX_REG = 1 it is a one-deep register stage with the R9 stall rules.
- R11: While rst_n is low, tx_out_valid and rx_out_valid (registered mode) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit word valid |
| tx_in_ready | output | 1 | Transmit word accepted |
| tx_in_data | input | 64 | Logical word to send |
| tx_out_valid | output | 1 | Coded beat valid |
| tx_out_ready | input | 1 | Bus side takes coded beat |
| tx_bus_wires | output | 64 | Wire levels to drive |
| tx_bus_flag_n | output | 4 | Per-group inversion flag wires, active-low |
| rx_in_valid | input | 1 | Sampled bus beat valid |
| rx_in_ready | output | 1 | Sampled beat accepted |
| rx_bus_wires | input | 64 | Sampled wire levels |
| rx_bus_flag_n | input | 4 | Sampled inversion flag wires |
| rx_out_valid | output | 1 | Restored word valid |
| rx_out_ready | input | 1 | Consumer takes restored word |
| rx_out_data | output | 64 | Restored logical word |

## Verification
The bench targets the threshold edge: groups with exactly 8 ones must stay plain, and groups with exactly 9 must flip. A comparator that is off by one, either `>=` or `> 9`, shows up as a wrong flag on one of these two words. It also feeds mixed words, where each group takes a different decision, to catch swapped group-to-flag wiring. It sends an inverted beat followed by a plain one, to catch a flag that sticks across phases. The receive side is driven through random back-pressure. A stage that drops or repeats a beat under stall loses scoreboard order, and one that lets its output move while stalled is flagged by the hold check.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int unsigned DBI_GRP_W   = 16;
  localparam int unsigned DBI_NUM_GRP = 4;

  // Strict-majority limit on low wires for a group of the given width.
  function automatic int unsigned low_limit(input int unsigned grp_w);
    return grp_w / 2;
  endfunction
endpackage

// File: rtl/dbi_grp_enc.sv
module dbi_grp_enc
  import dbi_pkg::*;
#(
  parameter int unsigned GRP_W = DBI_GRP_W
) (
  input  logic [GRP_W-1:0] data,
  output logic [GRP_W-1:0] wires,
  output logic             flag_n
);
  localparam int unsigned CW  = $clog2(GRP_W + 1);
  localparam int unsigned LIM = low_limit(GRP_W);

  logic [CW-1:0] ones;
  logic          flip;

  // A logical one becomes a low wire, so the ones count is the low-wire count.
  always_comb begin
    ones = '0;
    for (int i = 0; i < GRP_W; i++) begin
      ones = ones + CW'(data[i]);
    end
  end

  assign flip   = (ones > CW'(LIM));
  assign wires  = flip ? data : ~data;
  assign flag_n = ~flip;
endmodule

// File: rtl/dbi_grp_dec.sv
module dbi_grp_dec #(
  parameter int unsigned GRP_W = 16
) (
  input  logic [GRP_W-1:0] wires,
  input  logic             flag_n,
  output logic [GRP_W-1:0] data
);
  assign data = flag_n ? ~wires : wires;
endmodule

// File: rtl/dbi_pipe_reg.sv
module dbi_pipe_reg #(
  parameter int unsigned W      = 8,
  parameter bit          ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (ENABLE) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dat_q <= '0;
        end else if (in_valid && in_ready) begin
          dat_q <= in_data;
        end
      end
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int unsigned NUM_GRP = DBI_NUM_GRP,
  parameter int unsigned GRP_W   = DBI_GRP_W,
  parameter bit          RX_REG  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_in_valid,
  output logic                     tx_in_ready,
  input  logic [NUM_GRP*GRP_W-1:0] tx_in_data,
  output logic                     tx_out_valid,
  input  logic                     tx_out_ready,
  output logic [NUM_GRP*GRP_W-1:0] tx_bus_wires,
  output logic [NUM_GRP-1:0]       tx_bus_flag_n,
  input  logic                     rx_in_valid,
  output logic                     rx_in_ready,
  input  logic [NUM_GRP*GRP_W-1:0] rx_bus_wires,
  input  logic [NUM_GRP-1:0]       rx_bus_flag_n,
  output logic                     rx_out_valid,
  input  logic                     rx_out_ready,
  output logic [NUM_GRP*GRP_W-1:0] rx_out_data
);
  localparam int unsigned DW  = NUM_GRP * GRP_W;
  localparam int unsigned TXW = DW + NUM_GRP;

  logic [DW-1:0]      enc_wires;
  logic [NUM_GRP-1:0] enc_flag_n;
  logic [DW-1:0]      dec_data;

  // Per-group coders; each group decides alone.
  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      dbi_grp_enc #(.GRP_W(GRP_W)) enc_i (
        .data   (tx_in_data[g*GRP_W +: GRP_W]),
        .wires  (enc_wires[g*GRP_W +: GRP_W]),
        .flag_n (enc_flag_n[g])
      );
      dbi_grp_dec #(.GRP_W(GRP_W)) dec_i (
        .wires  (rx_bus_wires[g*GRP_W +: GRP_W]),
        .flag_n (rx_bus_flag_n[g]),
        .data   (dec_data[g*GRP_W +: GRP_W])
      );
    end
  endgenerate

  // Transmit: coded wires and flags registered together.
  dbi_pipe_reg #(.W(TXW), .ENABLE(1'b1)) tx_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({enc_flag_n, enc_wires}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  ({tx_bus_flag_n, tx_bus_wires})
  );

  // Receive: optional register after the decoder.
  dbi_pipe_reg #(.W(DW), .ENABLE(RX_REG)) rx_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (dec_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data)
  );
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned GRP_W   = 16,
  parameter bit          RX_REG  = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tx_in_valid,
  input logic                     tx_in_ready,
  input logic                     tx_out_valid,
  input logic                     tx_out_ready,
  input logic [NUM_GRP*GRP_W-1:0] tx_bus_wires,
  input logic [NUM_GRP-1:0]       tx_bus_flag_n,
  input logic                     rx_in_valid,
  input logic                     rx_in_ready,
  input logic                     rx_out_valid,
  input logic                     rx_out_ready,
  input logic [NUM_GRP*GRP_W-1:0] rx_out_data
);
  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lim
      AST_TX_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> ($countones(~tx_bus_wires[g*GRP_W +: GRP_W]) <= GRP_W / 2)); // R5
    end
  endgenerate

  AST_TX_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |-> !tx_in_ready); // R9

  AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=>
      (tx_out_valid && $stable(tx_bus_wires) && $stable(tx_bus_flag_n))); // R9

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready) |=> tx_out_valid); // R8

  generate
    if (RX_REG) begin : g_rx_reg
      AST_RX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data))); // R10
    end else begin : g_rx_comb
      AST_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid == rx_in_valid) && (rx_in_ready == rx_out_ready)); // R10
    end
  endgenerate
endmodule

bind dbi_codec dbi_codec_chk #(
  .NUM_GRP (NUM_GRP),
  .GRP_W   (GRP_W),
  .RX_REG  (RX_REG)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_in_valid   (tx_in_valid),
  .tx_in_ready   (tx_in_ready),
  .tx_out_valid  (tx_out_valid),
  .tx_out_ready  (tx_out_ready),
  .tx_bus_wires  (tx_bus_wires),
  .tx_bus_flag_n (tx_bus_flag_n),
  .rx_in_valid   (rx_in_valid),
  .rx_in_ready   (rx_in_ready),
  .rx_out_valid  (rx_out_valid),
  .rx_out_ready  (rx_out_ready),
  .rx_out_data   (rx_out_data)
);

// File: tb/dbi_codec_tb_top.sv
`timescale 1ns/1ps
module dbi_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;

  // Loopback DUT (registered receive).
  logic        tx_in_valid = 1'b0;
  logic        tx_in_ready;
  logic [63:0] tx_in_data = '0;
  logic        tx_out_valid;
  logic [63:0] tx_bus_wires;
  logic [3:0]  tx_bus_flag_n;
  logic        rx_in_ready;
  logic        rx_out_valid;
  logic        rx_out_ready = 1'b1;
  logic [63:0] rx_out_data;

  dbi_codec #(.RX_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(rx_in_ready),
    .tx_bus_wires(tx_bus_wires), .tx_bus_flag_n(tx_bus_flag_n),
    .rx_in_valid(tx_out_valid), .rx_in_ready(rx_in_ready),
    .rx_bus_wires(tx_bus_wires), .rx_bus_flag_n(tx_bus_flag_n),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  // Second instance: combinational receive, driven directly.
  logic        c_tx_in_ready, c_tx_out_valid;
  logic [63:0] c_tx_bus_wires;
  logic [3:0]  c_tx_bus_flag_n;
  logic        c_rx_in_valid = 1'b0;
  logic        c_rx_in_ready;
  logic [63:0] c_rx_wires = '0;
  logic [3:0]  c_rx_flag_n = '1;
  logic        c_rx_out_valid;
  logic        c_rx_out_ready = 1'b0;
  logic [63:0] c_rx_out_data;

  dbi_codec #(.RX_REG(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(1'b0), .tx_in_ready(c_tx_in_ready), .tx_in_data(64'd0),
    .tx_out_valid(c_tx_out_valid), .tx_out_ready(1'b1),
    .tx_bus_wires(c_tx_bus_wires), .tx_bus_flag_n(c_tx_bus_flag_n),
    .rx_in_valid(c_rx_in_valid), .rx_in_ready(c_rx_in_ready),
    .rx_bus_wires(c_rx_wires), .rx_bus_flag_n(c_rx_flag_n),
    .rx_out_valid(c_rx_out_valid), .rx_out_ready(c_rx_out_ready), .rx_out_data(c_rx_out_data)
  );

  logic [67:0] exp_tx_q[$];
  logic [63:0] exp_rx_q[$];

  function automatic logic [67:0] enc_model(input logic [63:0] d);
    logic [63:0] w;
    logic [3:0]  f;
    for (int g = 0; g < 4; g++) begin
      int cnt = 0;
      for (int i = 0; i < 16; i++) cnt += int'(d[16*g+i]);
      if (cnt > 8) begin
        w[16*g +: 16] = d[16*g +: 16];
        f[g] = 1'b0;
      end else begin
        w[16*g +: 16] = ~d[16*g +: 16];
        f[g] = 1'b1;
      end
    end
    return {f, w};
  endfunction

  function automatic logic [63:0] dec_model(input logic [63:0] w, input logic [3:0] f);
    logic [63:0] d;
    for (int g = 0; g < 4; g++)
      d[16*g +: 16] = f[g] ? ~w[16*g +: 16] : w[16*g +: 16];
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: call at a negedge.
  task automatic send(input logic [63:0] w);
    tx_in_valid = 1'b1;
    tx_in_data  = w;
    #1;
    while (!tx_in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_tx_q.push_back(enc_model(w));
    exp_rx_q.push_back(w);
    @(posedge clk);
    @(negedge clk);
    tx_in_valid = 1'b0;
    check(tx_out_valid === 1'b1, "R8 latency", {67'd0, tx_out_valid}, 68'd1);
  endtask

  // Consumer ready pattern.
  always @(negedge clk) begin
    rx_out_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitors.
  logic        hold_pend = 1'b0;
  logic [67:0] hold_val;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hold_pend) begin
        check({tx_bus_flag_n, tx_bus_wires} === hold_val && tx_out_valid,
              "R9 hold", {tx_bus_flag_n, tx_bus_wires}, hold_val);
        hold_pend = 1'b0;
      end
      if (tx_out_valid && !rx_in_ready) begin
        check(tx_in_ready === 1'b0, "R9 ready", {67'd0, tx_in_ready}, 68'd0);
        hold_pend = 1'b1;
        hold_val  = {tx_bus_flag_n, tx_bus_wires};
      end
      if (tx_out_valid && rx_in_ready) begin
        if (exp_tx_q.size() == 0) begin
          check(1'b0, "R1 R3 R4 R7 unexpected tx beat", {tx_bus_flag_n, tx_bus_wires}, 68'd0);
        end else begin
          logic [67:0] e;
          e = exp_tx_q.pop_front();
          check({tx_bus_flag_n, tx_bus_wires} === e, "R1 R2 R3 R4 R7 encode",
                {tx_bus_flag_n, tx_bus_wires}, e);
        end
      end
      if (rx_out_valid && rx_out_ready) begin
        if (exp_rx_q.size() == 0) begin
          check(1'b0, "R6 unexpected rx beat", {4'd0, rx_out_data}, 68'd0);
        end else begin
          logic [63:0] e;
          e = exp_rx_q.pop_front();
          check(rx_out_data === e, "R6 R10 roundtrip", {4'd0, rx_out_data}, {4'd0, e});
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 68'd0, 68'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(tx_out_valid === 1'b0 && rx_out_valid === 1'b0, "R11 reset",
          {66'd0, tx_out_valid, rx_out_valid}, 68'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Boundary words: threshold edge, all-zero, all-one, mixed groups (R3 R4 R1).
    send(64'h0);
    send(64'hFFFF_FFFF_FFFF_FFFF);
    send(64'h00FF_00FF_00FF_00FF);  // exactly 8 per group: plain
    send(64'h01FF_01FF_01FF_01FF);  // exactly 9 per group: inverted
    send(64'h01FF_00FF_FFFF_0000);  // each group decides differently
    send(64'h0000_FFFF_00FF_01FF);
    // R7: inverted beat followed by plain beat.
    send(64'hFFFF_FFFF_FFFF_FFFF);
    send(64'h0001_0001_0001_0001);

    // Random traffic with back-pressure.
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send({$urandom, $urandom});
    end
    stall_mode = 1'b0;
    for (int n = 0; n < 50 && exp_rx_q.size() != 0; n++) @(negedge clk);
    check(exp_rx_q.size() == 0 && exp_tx_q.size() == 0, "R6 drain",
          68'(exp_rx_q.size()), 68'd0);

    // R10 / R2: combinational receive instance.
    @(negedge clk);
    c_rx_in_valid  = 1'b1;
    c_rx_out_ready = 1'b0;
    c_rx_wires     = 64'h1234_5678_9ABC_DEF0;
    c_rx_flag_n    = 4'b0101;
    #1;
    check(c_rx_out_data === dec_model(c_rx_wires, c_rx_flag_n), "R2 R6 comb decode",
          {4'd0, c_rx_out_data}, {4'd0, dec_model(c_rx_wires, c_rx_flag_n)});
    check(c_rx_out_valid === 1'b1 && c_rx_in_ready === 1'b0, "R10 comb pass",
          {66'd0, c_rx_out_valid, c_rx_in_ready}, 68'b10);
    @(negedge clk);
    c_rx_in_valid  = 1'b0;
    c_rx_out_ready = 1'b1;
    c_rx_flag_n    = 4'b1010;
    #1;
    check(c_rx_out_valid === 1'b0 && c_rx_in_ready === 1'b1, "R10 comb pass idle",
          {66'd0, c_rx_out_valid, c_rx_in_ready}, 68'b01);
    check(c_rx_out_data === dec_model(c_rx_wires, 4'b1010), "R1 R2 comb decode",
          {4'd0, c_rx_out_data}, {4'd0, dec_model(c_rx_wires, 4'b1010)});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule